// File: doc/BRIEF.md
# Sequential Multiply-Divide Unit

This block multiplies and divides integers, signed or unsigned, at byte or word size. Its operands sit in accumulator positions: a low accumulator word, a high accumulator word and a separate source operand. A one-cycle `start` pulse captures all inputs and the selected operation. A fixed number of cycles later the unit raises `done` for one cycle. The results appear on `res_hi` and `res_lo` in that cycle and stay there until the next operation finishes.

Multiplication uses a shift-and-add loop and division uses a restoring shift-and-subtract loop. Both work on operand magnitudes, and the signs are applied at the end. A division whose quotient cannot fit its destination, or whose divisor is zero, sets `div_err` instead of producing a result. In that case the result outputs return the captured accumulator words unchanged.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `res_hi`, `res_lo`, `done` and `div_err` are all zero.
- R2: Byte multiply (`op_div`=0, `size_word`=0) multiplies `acc_lo[7:0]` by `src[7:0]`. The 16-bit product goes to `res_lo`, and `res_hi` returns the captured `acc_hi`. Unsigned 85h times 35h gives `res_lo`=1B89h.
- R3: Word multiply (`size_word`=1) multiplies `acc_lo` by `src`. Product bits 31..16 go to `res_hi` and bits 15..0 go to `res_lo`.
- R4: With `is_signed`=1, multiply operands are two's complement at the selected size. Byte 85h times 35h gives `res_lo`=E689h.
- R5: Byte divide divides `acc_lo` (16 bits) by `src[7:0]`. The quotient goes to `res_lo[7:0]` and the remainder to `res_lo[15:8]`, and `res_hi` returns `acc_hi`. Unsigned 00F3h divided by 91h gives `res_lo`=6201h.
- R6: Word divide divides `{acc_hi,acc_lo}` by `src`. The quotient goes to `res_lo` and the remainder to `res_hi`.
- R7: A signed divide truncates toward zero. The quotient is negative when the operand signs differ, and the remainder carries the dividend's sign. Byte 00F3h divided by 91h gives `res_lo`=15FEh.
- R8: An unsigned quotient above FFh (byte) or FFFFh (word) sets `div_err` alongside `done`. In that case `res_hi`/`res_lo` equal the captured `acc_hi`/`acc_lo`.
- R9: A signed quotient whose magnitude exceeds 7Fh (byte) or 7FFFh (word) is treated the same as in R8, including magnitude 80h.
- R10: A zero divisor is treated the same as in R8.
- R11: `done` is high for exactly one cycle. It rises in the cycle after the N+2-th rising edge that follows the edge capturing `start`, where N is 8 for byte and 16 for word operations.
- R12: A `start` pulse that arrives while an operation is in progress has no effect on that operation's results or timing.
- R13: `res_hi`/`res_lo` change only in a `done` cycle. `div_err` is high only together with `done`, and a multiply never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an operation (sampled while idle) |
| op_div | input | 1 | 0 = multiply, 1 = divide |
| is_signed | input | 1 | Treat operands as two's complement |
| size_word | input | 1 | 0 = byte form, 1 = word form |
| acc_hi | input | 16 | High accumulator word |
| acc_lo | input | 16 | Low accumulator word |
| src | input | 16 | Source operand (multiplier or divisor) |
| res_hi | output | 16 | New high accumulator word |
| res_lo | output | 16 | New low accumulator word |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Divide error, valid with done |

## Verification
A corrupted magnitude, partial product or remainder in the loop never surfaces mid-operation. It shows up only as a wrong `res_hi`/`res_lo` in the single `done` cycle, N+2 cycles after start. Sign errors therefore appear only on mixed-sign operands, and range-check errors only on quotients close to the signed or unsigned limits. The bench aims its directed cases at exactly those limits. A state or counter fault shows as `done` arriving early, late or twice, which the per-operation latency count catches at once.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    MD_IDLE = 2'd0,
    MD_PREP = 2'd1,
    MD_LOOP = 2'd2,
    MD_FIN  = 2'd3
  } md_state_e;
endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int WW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic word_sel,
  output logic cap_en,
  output logic prep_en,
  output logic loop_en,
  output logic fin_en,
  output logic done
);
  localparam int CW = $clog2(WW) + 1;
  localparam logic [CW-1:0] LAST_W = CW'(WW - 1);
  localparam logic [CW-1:0] LAST_B = CW'(WW / 2 - 1);

  md_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    case (st_q)
      MD_IDLE: if (start) st_d = MD_PREP;
      MD_PREP: begin
        st_d  = MD_LOOP;
        cnt_d = '0;
      end
      MD_LOOP: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == (word_sel ? LAST_W : LAST_B)) st_d = MD_FIN;
      end
      MD_FIN: begin
        st_d   = MD_IDLE;
        done_d = 1'b1;
      end
      default: st_d = MD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= MD_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign cap_en  = (st_q == MD_IDLE) && start;
  assign prep_en = (st_q == MD_PREP);
  assign loop_en = (st_q == MD_LOOP);
  assign fin_en  = (st_q == MD_FIN);
  assign done    = done_q;
endmodule

// File: rtl/muldiv_mul_step.sv
module muldiv_mul_step #(
  parameter int WW = 16
) (
  input  logic [2*WW-1:0] prod_i,
  input  logic [2*WW-1:0] mcand_i,
  input  logic [WW-1:0]   mplr_i,
  output logic [2*WW-1:0] prod_o,
  output logic [2*WW-1:0] mcand_o,
  output logic [WW-1:0]   mplr_o
);
  always_comb begin
    prod_o  = mplr_i[0] ? (prod_i + mcand_i) : prod_i;
    mcand_o = mcand_i << 1;
    mplr_o  = mplr_i >> 1;
  end
endmodule

// File: rtl/muldiv_div_step.sv
module muldiv_div_step #(
  parameter int WW = 16
) (
  input  logic [WW-1:0] rem_i,
  input  logic [WW-1:0] dvd_i,
  input  logic [WW-1:0] dvs_i,
  input  logic [WW-1:0] quo_i,
  output logic [WW-1:0] rem_o,
  output logic [WW-1:0] dvd_o,
  output logic [WW-1:0] quo_o
);
  logic [WW:0] trial;
  logic [WW:0] diff;
  logic        fits;

  always_comb begin
    trial = {rem_i, dvd_i[WW-1]};
    diff  = trial - {1'b0, dvs_i};
    fits  = (trial >= {1'b0, dvs_i});
    rem_o = fits ? diff[WW-1:0] : trial[WW-1:0];
    dvd_o = dvd_i << 1;
    quo_o = {quo_i[WW-2:0], fits};
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_div,
  input  logic          is_signed,
  input  logic          size_word,
  input  logic [WW-1:0] acc_hi,
  input  logic [WW-1:0] acc_lo,
  input  logic [WW-1:0] src,
  output logic [WW-1:0] res_hi,
  output logic [WW-1:0] res_lo,
  output logic          done,
  output logic          div_err
);
  localparam int HW = WW / 2;
  localparam int DW = 2 * WW;
  localparam logic [WW-1:0] SLIM_W = {1'b0, {(WW-1){1'b1}}};
  localparam logic [WW-1:0] SLIM_B = {{(HW+1){1'b0}}, {(HW-1){1'b1}}};

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  logic cap_en, prep_en, loop_en, fin_en;

  // captured operation
  logic [WW-1:0] hi_q, lo_q, src_q;
  logic          div_q, sgn_q, word_q;

  muldiv_ctrl #(.WW(WW)) u_ctrl (
    .clk(clk), .rst_n(rst_i_n), .start(start), .word_sel(word_q),
    .cap_en(cap_en), .prep_en(prep_en), .loop_en(loop_en),
    .fin_en(fin_en), .done(done)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      hi_q <= '0; lo_q <= '0; src_q <= '0;
      div_q <= 1'b0; sgn_q <= 1'b0; word_q <= 1'b0;
    end else if (cap_en) begin
      hi_q <= acc_hi; lo_q <= acc_lo; src_q <= src;
      div_q <= op_div; sgn_q <= is_signed; word_q <= size_word;
    end
  end

  // operand extension and magnitude
  logic [DW-1:0] a_ext, a_mag;
  logic [WW-1:0] b_ext, b_mag, hi_part;
  logic          a_neg, b_neg;

  always_comb begin
    b_neg = sgn_q && (size_word_sel(word_q) ? src_q[WW-1] : src_q[HW-1]);
    b_ext = word_q ? src_q : {{(WW-HW){b_neg}}, src_q[HW-1:0]};
    if (div_q && word_q) begin
      a_neg = sgn_q && hi_q[WW-1];
      a_ext = {hi_q, lo_q};
    end else if (div_q || word_q) begin
      a_neg = sgn_q && lo_q[WW-1];
      a_ext = {{WW{a_neg}}, lo_q};
    end else begin
      a_neg = sgn_q && lo_q[HW-1];
      a_ext = {{(DW-HW){a_neg}}, lo_q[HW-1:0]};
    end
    a_mag   = a_neg ? (~a_ext + 1'b1) : a_ext;
    b_mag   = b_neg ? (~b_ext + 1'b1) : b_ext;
    hi_part = word_q ? a_mag[DW-1:WW] : {{HW{1'b0}}, a_mag[WW-1:HW]};
  end

  function automatic logic size_word_sel(input logic w);
    return w;
  endfunction

  // iteration state
  logic [DW-1:0] prod_q, prod_d, mcand_q, mcand_d, prod_s, mcand_s;
  logic [WW-1:0] mplr_q, mplr_d, mplr_s;
  logic [WW-1:0] rem_q, rem_d, rem_s, dvd_q, dvd_d, dvd_s, quo_q, quo_d, quo_s;
  logic          pre_err_q, pre_err_d, negq_q, negq_d, negr_q, negr_d;

  muldiv_mul_step #(.WW(WW)) u_mul (
    .prod_i(prod_q), .mcand_i(mcand_q), .mplr_i(mplr_q),
    .prod_o(prod_s), .mcand_o(mcand_s), .mplr_o(mplr_s)
  );

  muldiv_div_step #(.WW(WW)) u_div (
    .rem_i(rem_q), .dvd_i(dvd_q), .dvs_i(b_mag), .quo_i(quo_q),
    .rem_o(rem_s), .dvd_o(dvd_s), .quo_o(quo_s)
  );

  always_comb begin
    prod_d = prod_q; mcand_d = mcand_q; mplr_d = mplr_q;
    rem_d = rem_q; dvd_d = dvd_q; quo_d = quo_q;
    pre_err_d = pre_err_q; negq_d = negq_q; negr_d = negr_q;
    if (prep_en) begin
      prod_d    = '0;
      mcand_d   = a_mag;
      mplr_d    = b_mag;
      quo_d     = '0;
      rem_d     = hi_part;
      dvd_d     = word_q ? a_mag[WW-1:0] : {a_mag[HW-1:0], {HW{1'b0}}};
      pre_err_d = (hi_part >= b_mag);
      negq_d    = a_neg ^ b_neg;
      negr_d    = a_neg;
    end else if (loop_en) begin
      if (div_q) begin
        rem_d = rem_s; dvd_d = dvd_s; quo_d = quo_s;
      end else begin
        prod_d = prod_s; mcand_d = mcand_s; mplr_d = mplr_s;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      prod_q <= '0; mcand_q <= '0; mplr_q <= '0;
      rem_q <= '0; dvd_q <= '0; quo_q <= '0;
      pre_err_q <= 1'b0; negq_q <= 1'b0; negr_q <= 1'b0;
    end else if (prep_en || loop_en) begin
      prod_q <= prod_d; mcand_q <= mcand_d; mplr_q <= mplr_d;
      rem_q <= rem_d; dvd_q <= dvd_d; quo_q <= quo_d;
      pre_err_q <= pre_err_d; negq_q <= negq_d; negr_q <= negr_d;
    end
  end

  // sign fix, range check and destination mapping
  logic [DW-1:0] p_fix;
  logic [WW-1:0] q_fix, r_fix, res_hi_d, res_lo_d;
  logic          ovf, err_d;

  always_comb begin
    p_fix = negq_q ? (~prod_q + 1'b1) : prod_q;
    q_fix = negq_q ? (~quo_q + 1'b1) : quo_q;
    r_fix = negr_q ? (~rem_q + 1'b1) : rem_q;
    ovf   = pre_err_q || (sgn_q && (quo_q > (word_q ? SLIM_W : SLIM_B)));
    err_d = fin_en && div_q && ovf;
    if (!div_q) begin
      res_hi_d = word_q ? p_fix[DW-1:WW] : hi_q;
      res_lo_d = p_fix[WW-1:0];
    end else if (ovf) begin
      res_hi_d = hi_q;
      res_lo_d = lo_q;
    end else if (word_q) begin
      res_hi_d = r_fix;
      res_lo_d = q_fix;
    end else begin
      res_hi_d = hi_q;
      res_lo_d = {r_fix[HW-1:0], q_fix[HW-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      res_hi  <= '0;
      res_lo  <= '0;
      div_err <= 1'b0;
    end else begin
      div_err <= err_d;
      if (fin_en) begin
        res_hi <= res_hi_d;
        res_lo <= res_lo_d;
      end
    end
  end
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
  parameter int WW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          op_div,
  input logic          size_word,
  input logic [WW-1:0] acc_hi,
  input logic [WW-1:0] acc_lo,
  input logic [WW-1:0] res_hi,
  input logic [WW-1:0] res_lo,
  input logic          done,
  input logic          div_err
);
  logic          busy_q, div_l, word_l;
  logic [7:0]    cnt_q;
  logic [WW-1:0] hi_l, lo_l;
  logic [7:0]    lat_exp;

  assign lat_exp = word_l ? 8'(WW + 2) : 8'(WW / 2 + 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; cnt_q <= '0; div_l <= 1'b0; word_l <= 1'b0;
      hi_l <= '0; lo_l <= '0;
    end else if (start && (!busy_q || done)) begin
      busy_q <= 1'b1; cnt_q <= '0; div_l <= op_div; word_l <= size_word;
      hi_l <= acc_hi; lo_l <= acc_lo;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_q && cnt_q == lat_exp)); // R11
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |-> done); // R13
  AST_MUL_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_l) |-> !div_err); // R13
  AST_RES_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_hi) && $stable(res_lo))); // R13
  AST_ERR_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |-> (res_hi == hi_l && res_lo == lo_l)); // R8
  AST_BYTE_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !word_l) |-> (res_hi == hi_l)); // R2
endmodule

bind muldiv_unit muldiv_unit_chk #(.WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
  .size_word(size_word), .acc_hi(acc_hi), .acc_lo(acc_lo),
  .res_hi(res_hi), .res_lo(res_lo), .done(done), .div_err(div_err)
);

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, op_div, is_signed, size_word;
  logic [15:0] acc_hi, acc_lo, src;
  logic [15:0] res_hi, res_lo;
  logic        done, div_err;
  int          errors = 0;
  int          checks = 0;

  always #2 clk = ~clk;

  muldiv_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
    .is_signed(is_signed), .size_word(size_word), .acc_hi(acc_hi),
    .acc_lo(acc_lo), .src(src), .res_hi(res_hi), .res_lo(res_lo),
    .done(done), .div_err(div_err)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void ref_op(input logic d, s, w,
                                 input logic [15:0] ahi, alo, sr,
                                 output logic [15:0] eh, el, output logic ee);
    longint a, b, p, q, r, lim, umax;
    logic [63:0] v, qv, rv;
    eh = ahi; el = alo; ee = 1'b0;
    lim  = w ? 64'sd32767 : 64'sd127;
    umax = w ? 64'sd65535 : 64'sd255;
    if (!d) begin
      if (s) begin
        a = w ? longint'($signed(alo)) : longint'($signed(alo[7:0]));
        b = w ? longint'($signed(sr))  : longint'($signed(sr[7:0]));
      end else begin
        a = w ? longint'(alo) : longint'(alo[7:0]);
        b = w ? longint'(sr)  : longint'(sr[7:0]);
      end
      p = a * b; v = p;
      if (w) {eh, el} = v[31:0];
      else el = v[15:0];
    end else begin
      if (s) begin
        a = w ? longint'($signed({ahi, alo})) : longint'($signed(alo));
        b = w ? longint'($signed(sr)) : longint'($signed(sr[7:0]));
      end else begin
        a = w ? longint'({ahi, alo}) : longint'(alo);
        b = w ? longint'(sr) : longint'(sr[7:0]);
      end
      if (b == 0) ee = 1'b1;
      else begin
        q = a / b; r = a % b;
        if (s) ee = (q > lim) || (q < -lim);
        else   ee = (q > umax);
        if (!ee) begin
          qv = q; rv = r;
          if (w) begin el = qv[15:0]; eh = rv[15:0]; end
          else el = {rv[7:0], qv[7:0]};
        end
      end
    end
  endfunction

  function automatic string tag_of(input logic d, s, w, ee, input logic [15:0] sr);
    if (!d) return s ? "R4" : (w ? "R3" : "R2");
    if (ee) begin
      if ((w ? sr : {8'h00, sr[7:0]}) == 16'h0) return "R10";
      return s ? "R9" : "R8";
    end
    if (s) return "R7";
    return w ? "R6" : "R5";
  endfunction

  task automatic run_op(input logic d, s, w, input logic [15:0] ahi, alo, sr,
                        input bit poke);
    logic [15:0] eh, el;
    logic        ee;
    int          lat;
    string       t;
    ref_op(d, s, w, ahi, alo, sr, eh, el, ee);
    t = tag_of(d, s, w, ee, sr);
    @(negedge clk);
    op_div = d; is_signed = s; size_word = w;
    acc_hi = ahi; acc_lo = alo; src = sr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (done !== 1'b1 && lat < 64) begin
      @(negedge clk);
      lat++;
      if (poke && lat == 2) begin
        start = 1'b1; op_div = ~d; size_word = ~w;
        acc_hi = 16'($urandom); acc_lo = 16'($urandom); src = 16'($urandom);
      end else start = 1'b0;
    end
    check(poke ? "R12" : "R11", "latency", 32'(lat), w ? 32'd18 : 32'd10);
    check(t, "result", {res_hi, res_lo}, {eh, el});
    check(t, "div_err", {31'd0, div_err}, {31'd0, ee});
    @(negedge clk);
    check("R13", "done pulse and held result", {14'd0, done, div_err, res_lo},
          {14'd0, 1'b0, 1'b0, el});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic d, s, w;
    logic [15:0] ahi, alo, sr;
    void'($urandom(32'h5A17));
    rst_n = 1'b0; start = 1'b0; op_div = 1'b0; is_signed = 1'b0;
    size_word = 1'b0; acc_hi = '0; acc_lo = '0; src = '0;
    repeat (3) @(negedge clk);
    check("R1", "reset state", {res_hi, res_lo}, 32'h0);
    check("R1", "reset flags", {30'd0, done, div_err}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    run_op(0, 0, 0, 16'h1234, 16'h0085, 16'h0035, 0); // R2 1B89
    run_op(0, 1, 0, 16'h0000, 16'h0085, 16'h0035, 0); // R4 E689
    run_op(0, 0, 1, 16'h0000, 16'hF000, 16'h9015, 0); // R3
    run_op(0, 1, 1, 16'h0000, 16'h8000, 16'h8000, 0); // R4 word corner
    run_op(1, 0, 0, 16'hBEEF, 16'h00F3, 16'h0091, 0); // R5 6201
    run_op(1, 1, 0, 16'h0000, 16'h00F3, 16'h0091, 0); // R7 15FE
    run_op(1, 1, 0, 16'h0000, 16'h1250, 16'h0090, 0); // R7
    run_op(1, 0, 1, 16'h0000, 16'hF000, 16'h9015, 0); // R6
    run_op(1, 0, 0, 16'h5555, 16'h1000, 16'h0010, 0); // R8 quotient 100h
    run_op(1, 0, 1, 16'h9015, 16'h0000, 16'h9015, 0); // R8 word
    run_op(1, 1, 0, 16'h0000, 16'h0080, 16'h0001, 0); // R9 +128
    run_op(1, 1, 0, 16'h0000, 16'hFF80, 16'h0001, 0); // R9 -128
    run_op(1, 1, 0, 16'h0000, 16'hFF81, 16'h0001, 0); // R7 -127 fits
    run_op(1, 1, 1, 16'h0000, 16'h8000, 16'h0001, 0); // R9 word
    run_op(1, 0, 0, 16'hAAAA, 16'h1234, 16'hFF00, 0); // R10
    run_op(1, 1, 1, 16'h7777, 16'h1234, 16'h0000, 0); // R10 word
    run_op(0, 0, 1, 16'h0000, 16'h1234, 16'h5678, 1); // R12
    run_op(1, 1, 0, 16'h0000, 16'h00F3, 16'h0091, 1); // R12

    for (int i = 0; i < 400; i++) begin
      d = 1'($urandom); s = 1'($urandom); w = 1'($urandom);
      ahi = 16'($urandom); alo = 16'($urandom); sr = 16'($urandom);
      if (d && ($urandom % 4 != 0)) begin
        if (w) ahi = ahi % ((sr >> 1) | 16'h1);
        else alo[15:8] = alo[15:8] % ((sr[7:0] >> 1) | 8'h1);
      end
      run_op(d, s, w, ahi, alo, sr, (i % 50) == 7);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule